// File: doc/BRIEF.md
# Dual-Compare Output Pulse Generator

This block is a timer-driven compare channel that shapes a pulse on one output pin from two compare values held against a single free-running up-counter. The counter counts from zero up to a programmable period value and returns to zero on the next clock. A primary compare value sets the rising edge of the pulse. A secondary compare value sets the falling edge.

A 3-bit mode field selects the operation. Single-pulse mode produces exactly one pulse and then holds the pin low. Continuous mode re-arms on every timer period. Every other mode value keeps the pin low.

The rising edge appears one clock after the primary match. A falling edge caused by a secondary match raises a one-cycle interrupt flag two clocks later. When the secondary value lies beyond the period, the counter never reaches it, so the pin stays high. Registers are loaded through a simple select/data write port.

Top module: `dual_cmp_pulse`

## Requirements
- R1: While rst_ni is low and right after it is released, pulse_o and irq_o are 0 and the timer is 0.
- R2: A mode value other than 3'b100 or 3'b101 holds pulse_o low. A mode write whose value differs from the current mode returns the pulse sequencer to its waiting state, with pulse_o low from the next cycle.
- R3: pulse_o rises at the second clock edge after a cycle in which timer equals the primary value while the sequencer is waiting (one clock of delay after the match).
- R4: While pulse_o is high, a cycle in which timer equals the secondary value makes pulse_o low at the next clock edge.
- R5: The timer increments by one each clock. In the clock after it equals the period value, it becomes 0.
- R6: In mode 3'b100, after the falling edge pulse_o stays low until the mode field is written with a different value.
- R7: In mode 3'b101, after each falling edge the sequencer waits for the next primary match, so one pulse is made per timer period.
- R8: irq_o is a one-cycle pulse that goes high exactly two clocks after pulse_o is driven low by a secondary match. A drop caused by a mode change raises no flag.
- R9: If the secondary value exceeds the period, pulse_o stays high until the secondary value is rewritten to at most the period, the mode changes, or reset occurs.
- R10: A write with wr_en_i=1 loads wr_data_i on that clock edge into: sel 0 the period, sel 1 the primary value, sel 2 the secondary value, sel 3 the mode (bits 2:0). The new value takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 period, 1 primary, 2 secondary, 3 mode) |
| wr_data_i | input | W | Write data |
| pulse_o | output | 1 | Pulse output pin |
| irq_o | output | 1 | One-cycle interrupt flag |

## Verification
The hardest situation to reach from the ports is a secondary value beyond the period while the pin is already high. The pin must then stay high across several timer wraps, and the secondary value must later be rewritten at the right time to release it. The random stimulus draws secondary values up to a few counts past the period. A directed case parks the pin high over many wraps and then lowers the secondary value. Mid-run rewrites of the mode field and of the compare values are mixed in, so that restarts and aborted pulses are compared against a cycle-accurate model in the bench.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam logic [2:0] MODE_SINGLE = 3'b100;
  localparam logic [2:0] MODE_CONT   = 3'b101;
  localparam int unsigned IRQ_DLY    = 2;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_PRI    = 2'd1,
    SEL_SEC    = 2'd2,
    SEL_MODE   = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RISE = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } pst_e;
endpackage

// File: rtl/dcp_regs.sv
module dcp_regs import dcp_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] pri_o,
  output logic [W-1:0] sec_o,
  output logic [2:0]   mode_o,
  output logic         mode_chg_o
);
  logic [W-1:0] period_q, pri_q, sec_q;
  logic [2:0]   mode_q;

  assign mode_chg_o = wr_en_i && (wr_sel_i == SEL_MODE) && (wr_data_i[2:0] != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      pri_q    <= '0;
      sec_q    <= '0;
      mode_q   <= '0;
    end else if (wr_en_i) begin
      unique case (sel_e'(wr_sel_i))
        SEL_PERIOD: period_q <= wr_data_i;
        SEL_PRI:    pri_q    <= wr_data_i;
        SEL_SEC:    sec_q    <= wr_data_i;
        SEL_MODE:   mode_q   <= wr_data_i[2:0];
      endcase
    end
  end

  assign period_o = period_q;
  assign pri_o    = pri_q;
  assign sec_o    = sec_q;
  assign mode_o   = mode_q;

  // R10
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_MODE) |=> (mode_q == $past(wr_data_i[2:0])));
endmodule

// File: rtl/dcp_timer.sv
module dcp_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q == period_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == period_i) |=> (cnt_q == '0));
  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != period_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dcp_pulse_fsm.sv
module dcp_pulse_fsm import dcp_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] pri_i,
  input  logic [W-1:0] sec_i,
  input  logic [2:0]   mode_i,
  input  logic         mode_chg_i,
  output logic         pulse_o,
  output logic         fall_o
);
  pst_e state_q, state_d;
  logic active, single, hit_pri, hit_sec;

  assign single  = (mode_i == MODE_SINGLE);
  assign active  = single || (mode_i == MODE_CONT);
  assign hit_pri = (cnt_i == pri_i);
  assign hit_sec = (cnt_i == sec_i);

  always_comb begin
    state_d = state_q;
    fall_o  = 1'b0;
    if (mode_chg_i || !active) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: if (hit_pri) state_d = ST_RISE;
        ST_RISE: state_d = ST_HIGH;
        ST_HIGH: if (hit_sec) begin
          fall_o  = 1'b1;
          state_d = single ? ST_DONE : ST_WAIT;
        end
        ST_DONE: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  assign pulse_o = (state_q == ST_HIGH);

  // R3
  rise_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && hit_pri && active && !mode_chg_i) |=> (!pulse_o && state_q == ST_RISE));
  // R6
  single_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !mode_chg_i) |=> (state_q == ST_DONE));
  // R2
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active) |-> !pulse_o);
endmodule

// File: rtl/dcp_irq_dly.sv
module dcp_irq_dly import dcp_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic irq_o
);
  logic [IRQ_DLY:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= fall_i;
  end

  for (genvar i = 1; i <= IRQ_DLY; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[i] <= 1'b0;
      else         sh_q[i] <= sh_q[i-1];
    end
  end

  assign irq_o = sh_q[IRQ_DLY];
endmodule

// File: rtl/dual_cmp_pulse.sv
module dual_cmp_pulse import dcp_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic         pulse_o,
  output logic         irq_o
);
  logic [W-1:0] period, pri, sec, cnt;
  logic [2:0]   mode;
  logic         mode_chg, fall;

  dcp_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .period_o(period), .pri_o(pri), .sec_o(sec), .mode_o(mode), .mode_chg_o(mode_chg)
  );

  dcp_timer #(.W(W)) u_timer (
    .clk_i, .rst_ni, .period_i(period), .cnt_o(cnt)
  );

  dcp_pulse_fsm #(.W(W)) u_fsm (
    .clk_i, .rst_ni, .cnt_i(cnt), .pri_i(pri), .sec_i(sec), .mode_i(mode),
    .mode_chg_i(mode_chg), .pulse_o(pulse_o), .fall_o(fall)
  );

  dcp_irq_dly u_irq (
    .clk_i, .rst_ni, .fall_i(fall), .irq_o(irq_o)
  );

  // R8
  irq_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(pulse_o, 3) && !$past(pulse_o, 2)));
  // R8
  irq_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R9
  sec_beyond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && sec > period && $stable(sec) && !mode_chg) |=> pulse_o);
endmodule

// File: tb/dual_cmp_pulse_tb.sv
module dual_cmp_pulse_tb;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         pulse, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int rises = 0;

  always #2 clk = ~clk;

  dual_cmp_pulse #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .pulse_o(pulse), .irq_o(irq)
  );

  // cycle model built from the requirements
  logic [W-1:0] m_per, m_pri, m_sec, m_cnt;
  logic [2:0]   m_mode;
  int           m_st;  // 0 wait, 1 rise pending, 2 high, 3 done
  logic [2:0]   m_irq;

  function automatic bit is_act(logic [2:0] m);
    return (m == 3'b100) || (m == 3'b101);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_per = '1; m_pri = '0; m_sec = '0; m_mode = '0; m_cnt = '0; m_st = 0; m_irq = '0;
    end else begin
      bit chg, fl;
      int nst;
      chg = wr_en && wr_sel == 2'd3 && wr_data[2:0] != m_mode;
      fl = 1'b0;
      nst = m_st;
      if (chg || !is_act(m_mode)) nst = 0;
      else if (m_st == 0 && m_cnt == m_pri) nst = 1;
      else if (m_st == 1) nst = 2;
      else if (m_st == 2 && m_cnt == m_sec) begin
        fl = 1'b1;
        nst = (m_mode == 3'b100) ? 3 : 0;
      end
      if (nst == 2 && m_st != 2) rises++;
      m_st = nst;
      m_irq = {m_irq[1:0], fl};
      m_cnt = (m_cnt == m_per) ? '0 : m_cnt + 1'b1;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_per = wr_data;
          2'd1: m_pri = wr_data;
          2'd2: m_sec = wr_data;
          default: m_mode = wr_data[2:0];
        endcase
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(pulse, m_st == 2,
          m_mode == 3'b100 ? "R6 single pulse" :
          m_mode == 3'b101 ? "R7 continuous pulse" : "R2 idle pulse");
      chk(irq, m_irq[2], "R8 irq timing");
    end
  end

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'h5eed);
    #1;
    chk(pulse, 1'b0, "R1 reset pulse");
    chk(irq, 1'b0, "R1 reset irq");
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pulse, 1'b0, "R1 pulse after release");

    // directed R3/R4/R8: period 9, rise after pri=2, fall at sec=6, continuous
    wr(2'd0, 16'd9); wr(2'd1, 16'd2); wr(2'd2, 16'd6); wr(2'd3, 16'd5);
    idle(40);
    chk(rises > 2, 1'b1, "R7 multiple pulses");

    // directed R6: single mode stays low after one pulse
    wr(2'd3, 16'd4);
    rises = 0;
    idle(60);
    chk(rises == 1, 1'b1, "R6 exactly one pulse");
    chk(pulse, 1'b0, "R6 held low");

    // directed R9: sec beyond period keeps pin high across wraps
    wr(2'd2, 16'd20);
    wr(2'd3, 16'd5);
    idle(50);
    chk(pulse, 1'b1, "R9 stays high");
    wr(2'd2, 16'd4);
    idle(15);
    chk(rises > 1, 1'b1, "R9 released");

    // directed R5: pri equal to period, rise right after wrap
    wr(2'd1, 16'd9);
    idle(30);

    // directed R2: non-pulse mode and restart
    wr(2'd3, 16'd3);
    idle(20);
    chk(pulse, 1'b0, "R2 mode 3 low");
    wr(2'd3, 16'd5);
    wr(2'd3, 16'd5);  // same value, no restart
    idle(20);

    // random segments, model compares every cycle
    for (int seg = 0; seg < 60; seg++) begin
      int p;
      p = 3 + int'($urandom_range(0, 30));
      wr(2'd0, W'(p));
      wr(2'd1, W'($urandom_range(0, p)));
      wr(2'd2, W'($urandom_range(0, p + 4)));
      case ($urandom_range(0, 3))
        0: wr(2'd3, 16'd4);
        1: wr(2'd3, 16'd5);
        2: wr(2'd3, W'($urandom_range(0, 7)));
        default: ;
      endcase
      for (int k = 0; k < 200; k++) begin
        if ($urandom_range(0, 99) == 0) wr(2'($urandom_range(1, 3)), W'($urandom_range(0, p + 2)));
        else idle(1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule